// File: doc/BRIEF.md
# Scratchpad Write Engine with CRC16

This block sits behind a serial bus front end that already turns bit slots into bytes. It handles a write-to-scratchpad transaction. The transaction opens with a command byte of 0Fh and continues with two target-address bytes. Every byte after those is data, and the data bytes land in an 8-byte scratchpad, starting at index 0.

The low target-address byte is latched with its three lowest bits forced to zero. The CRC16 is computed differently: it runs over the command byte, both address bytes exactly as they arrived, and every stored data byte. A status byte records two things: the index of the last complete data byte and a partial-byte flag. The flag is set when the bus aborts while a byte is only half received; that incomplete byte is thrown away.

Once all eight scratchpad bytes are filled, the master can issue read requests. The first two return the CRC, inverted. Every later read returns all ones. Bytes stored before an abort are kept.

Top module: `spadWriteEngine`

## Requirements
- R1: After reset, taLo, taHi, esByte and padData read zero, txReady is low and txData is FFh.
- R2: The first byte after reset or abort starts a transaction only if it equals 0Fh and abortIn is low in that cycle. Any other first byte makes the block ignore the rest of the stream until abortIn, leaving all outputs unchanged.
- R3: The byte after the command appears on taLo with bits 2..0 forced to 000. The byte after that appears unchanged on taHi. Both hold their values until the next transaction latches them again.
- R4: Data bytes are written to scratchpad indices 0, 1, 2 and onward, with index i at padData[8i+7:8i]. esByte[2:0] holds the index of the last stored byte and is 0 when no data byte has arrived. Indices that are not written keep their previous contents.
- R5: The CRC is cleared when a transaction starts. It absorbs the command, TA1 as received (bits 2..0 included), TA2 and each stored data byte. Each byte enters LSB first, using polynomial x^16+x^15+x^2+1 (reflected constant A001h).
- R6: After the eighth data byte, the first read returns the inverted CRC low byte and the second returns the inverted CRC high byte. Every further read returns FFh.
- R7: A read issued before the scratchpad is full, or outside a transaction, returns FFh. A data byte that arrives after the scratchpad is full is neither stored nor absorbed.
- R8: When abortIn rises while bitPending is high during the data phase, esByte[5] (the partial-byte flag) is set and no byte is stored for the unfinished slot. Bytes stored earlier stay in place.
- R9: An abort while bitPending is low leaves esByte[5] unchanged. The start of a new transaction clears esByte[5] and esByte[2:0].
- R10: txReady goes high for exactly the one cycle after a cycle with txReq high, and txData is valid in that cycle.
- R11: A complete data byte presented in the same cycle as abortIn is stored, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | rxData holds a complete received byte |
| rxData | input | 8 | Received byte |
| bitPending | input | 1 | Front end has started a byte that is not yet complete |
| abortIn | input | 1 | Bus reset; ends the transaction |
| txReq | input | 1 | Master requests a byte to be sent |
| txReady | output | 1 | txData is valid (one cycle after txReq) |
| txData | output | 8 | Byte to send |
| taLo | output | 8 | Latched low target address, bits 2..0 zero |
| taHi | output | 8 | Latched high target address |
| esByte | output | 8 | Status: bit 5 partial flag, bits 2..0 ending offset |
| padData | output | 64 | Scratchpad contents, byte i at bits 8i+7..8i |

## Verification
Two functions can fall in the same cycle: an abort, and the acceptance of a byte. The bench drives abortIn together with rxValid in two situations. In the data phase, the byte must be stored and the ending offset must move to it, while the partial flag must follow bitPending alone. In idle, with a 0Fh byte, no transaction may start, which the bench shows by sending a follow-up byte and seeing that taLo keeps its value.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TA1,
    ST_TA2,
    ST_DATA,
    ST_FULL,
    ST_SKIP
  } spadState_t;

  typedef struct packed {
    logic startTxn;
    logic absorb;
    logic latchTa1;
    logic latchTa2;
    logic storeData;
    logic setPf;
    logic txCrc;
  } spadStrobe_t;

  localparam logic [15:0] CRC_POLY_REV = 16'hA001;

  function automatic logic [15:0] crcStep(input logic [15:0] crcIn, input logic [7:0] b);
    logic [15:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c = c >> 1;
      if (fb) c = c ^ CRC_POLY_REV;
    end
    return c;
  endfunction

endpackage

// File: rtl/spadCtrl.sv
module spadCtrl
  import spad_pkg::*;
#(
  parameter logic [7:0] CMD_CODE = 8'h0F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        bitPending,
  input  logic        abortIn,
  input  logic        txReq,
  input  logic        wrLast,
  output spadStrobe_t stb
);

  spadState_t state, nextState;

  always_comb begin
    stb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (rxValid && !abortIn) begin
          if (rxData == CMD_CODE) begin
            stb.startTxn = 1'b1;
            nextState = ST_TA1;
          end else begin
            nextState = ST_SKIP;
          end
        end
      end
      ST_TA1: begin
        if (rxValid) begin
          stb.absorb = 1'b1;
          stb.latchTa1 = 1'b1;
          nextState = ST_TA2;
        end
      end
      ST_TA2: begin
        if (rxValid) begin
          stb.absorb = 1'b1;
          stb.latchTa2 = 1'b1;
          nextState = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rxValid) begin
          stb.absorb = 1'b1;
          stb.storeData = 1'b1;
          if (wrLast) nextState = ST_FULL;
        end
        if (abortIn && bitPending) stb.setPf = 1'b1;
      end
      ST_FULL: begin
        if (txReq) stb.txCrc = 1'b1;
      end
      ST_SKIP: begin
        nextState = ST_SKIP;
      end
      default: nextState = ST_IDLE;
    endcase
    if (abortIn) nextState = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/spadDatapath.sv
module spadDatapath
  import spad_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ADDR_CLR_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spadStrobe_t          stb,
  input  logic [7:0]           rxData,
  input  logic                 txReq,
  output logic                 wrLast,
  output logic                 txReady,
  output logic [7:0]           txData,
  output logic [7:0]           taLo,
  output logic [7:0]           taHi,
  output logic [7:0]           esByte,
  output logic [DEPTH*8-1:0]   padData
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int PF_BIT = 5;

  logic [PTR_W-1:0] wrCount;
  logic [PTR_W-1:0] endOff;
  logic             pfFlag;
  logic [15:0]      crcReg;
  logic [1:0]       txIdx;

  assign wrLast = (wrCount == PTR_W'(DEPTH - 1));

  // CRC register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             crcReg <= '0;
    else if (stb.startTxn) crcReg <= crcStep(16'h0000, rxData);
    else if (stb.absorb)   crcReg <= crcStep(crcReg, rxData);
  end

  // address latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taLo <= '0;
      taHi <= '0;
    end else begin
      if (stb.latchTa1) taLo <= {rxData[7:ADDR_CLR_BITS], {ADDR_CLR_BITS{1'b0}}};
      if (stb.latchTa2) taHi <= rxData;
    end
  end

  // write pointer, ending offset and partial flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCount <= '0;
      endOff  <= '0;
      pfFlag  <= 1'b0;
    end else if (stb.startTxn) begin
      wrCount <= '0;
      endOff  <= '0;
      pfFlag  <= 1'b0;
    end else begin
      if (stb.storeData) begin
        endOff  <= wrCount;
        wrCount <= wrCount + 1'b1;
      end
      if (stb.setPf) pfFlag <= 1'b1;
    end
  end

  // scratchpad byte lanes
  for (genvar g = 0; g < DEPTH; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) padData[g*8 +: 8] <= '0;
      else if (stb.storeData && wrCount == PTR_W'(g)) padData[g*8 +: 8] <= rxData;
    end
  end

  always_comb begin
    esByte = '0;
    esByte[PF_BIT] = pfFlag;
    esByte[PTR_W-1:0] = endOff;
  end

  // transmit path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReady <= 1'b0;
      txData  <= 8'hFF;
      txIdx   <= '0;
    end else begin
      txReady <= txReq;
      if (stb.startTxn) txIdx <= '0;
      if (txReq) begin
        if (stb.txCrc) begin
          unique case (txIdx)
            2'd0:    txData <= ~crcReg[7:0];
            2'd1:    txData <= ~crcReg[15:8];
            default: txData <= 8'hFF;
          endcase
          if (txIdx != 2'd2) txIdx <= txIdx + 1'b1;
        end else begin
          txData <= 8'hFF;
        end
      end
    end
  end

endmodule

// File: rtl/spadWriteEngine.sv
module spadWriteEngine #(
  parameter int         DEPTH = 8,
  parameter logic [7:0] CMD_CODE = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              bitPending,
  input  logic              abortIn,
  input  logic              txReq,
  output logic              txReady,
  output logic [7:0]        txData,
  output logic [7:0]        taLo,
  output logic [7:0]        taHi,
  output logic [7:0]        esByte,
  output logic [DEPTH*8-1:0] padData
);

  spad_pkg::spadStrobe_t stb;
  logic wrLast;

  spadCtrl #(.CMD_CODE(CMD_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .bitPending(bitPending), .abortIn(abortIn), .txReq(txReq),
    .wrLast(wrLast), .stb(stb)
  );

  spadDatapath #(.DEPTH(DEPTH), .ADDR_CLR_BITS(3)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData), .txReq(txReq),
    .wrLast(wrLast), .txReady(txReady), .txData(txData), .taLo(taLo),
    .taHi(taHi), .esByte(esByte), .padData(padData)
  );

endmodule

// File: rtl/spadWriteEngineChk.sv
module spadWriteEngineChk #(
  parameter int DEPTH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              bitPending,
  input logic              abortIn,
  input logic              txReq,
  input logic              txReady,
  input logic [7:0]        taLo,
  input logic [7:0]        taHi,
  input logic [7:0]        esByte,
  input logic [DEPTH*8-1:0] padData
);

  AST_TA1_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    taLo[2:0] == 3'b000); // R3

  AST_TA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(taLo) && $stable(taHi))); // R3

  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(padData)); // R4

  AST_PF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(esByte[5]) |-> $past(abortIn && bitPending)); // R8

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> txReady); // R10

  AST_READY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> $past(txReq)); // R10

endmodule

bind spadWriteEngine spadWriteEngineChk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .bitPending(bitPending),
  .abortIn(abortIn), .txReq(txReq), .txReady(txReady), .taLo(taLo),
  .taHi(taHi), .esByte(esByte), .padData(padData)
);

// File: tb/spadWriteEngine_test.sv
`timescale 1ns/1ps
module spadWriteEngine_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic bitPending = 1'b0;
  logic abortIn = 1'b0;
  logic txReq = 1'b0;
  logic txReady;
  logic [7:0] txData, taLo, taHi, esByte;
  logic [63:0] padData;

  int checks = 0;
  int failures = 0;
  logic [7:0] mpad [8];
  logic [15:0] mcrc;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  spadWriteEngine uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .bitPending(bitPending), .abortIn(abortIn), .txReq(txReq),
    .txReady(txReady), .txData(txData), .taLo(taLo), .taHi(taHi),
    .esByte(esByte), .padData(padData)
  );

  // vector: ta1[84:77] ta2[76:69] count[68:65] pending[64] data[63:0]
  localparam logic [84:0] VEC [4] = '{
    {8'hA5, 8'h01, 4'd8, 1'b0, 64'h8877665544332211},
    {8'h3F, 8'h00, 4'd3, 1'b1, 64'h0000000000C3B2A1},
    {8'h80, 8'h00, 4'd1, 1'b0, 64'h000000000000005A},
    {8'hFF, 8'h12, 4'd8, 1'b1, 64'h0123456789ABCDEF}
  };

  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxData = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic doAbort(input logic pend, input logic withByte, input logic [7:0] b);
    @(negedge clk); abortIn = 1'b1; bitPending = pend; rxValid = withByte; rxData = b;
    @(negedge clk); abortIn = 1'b0; bitPending = 1'b0; rxValid = 1'b0;
  endtask

  task automatic readByte(input string req, output logic [7:0] v);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    chk({req, " R10 ready"}, {63'd0, txReady}, 64'd1);
    v = txData;
    @(negedge clk);
    chk("R10 ready one cycle", {63'd0, txReady}, 64'd0);
  endtask

  function automatic logic [63:0] modelPad();
    logic [63:0] p;
    for (int k = 0; k < 8; k++) p[k*8 +: 8] = mpad[k];
    return p;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) mpad[k] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 taLo", {56'd0, taLo}, 64'd0);
    chk("R1 taHi", {56'd0, taHi}, 64'd0);
    chk("R1 esByte", {56'd0, esByte}, 64'd0);
    chk("R1 pad", padData, 64'd0);
    chk("R1 txReady", {63'd0, txReady}, 64'd0);
    chk("R1 txData", {56'd0, txData}, 64'hFF);

    // table-driven transactions
    for (int v = 0; v < 4; v++) begin
      logic [7:0] t1, t2;
      int n;
      t1 = VEC[v][84:77];
      t2 = VEC[v][76:69];
      n = int'(VEC[v][68:65]);
      mcrc = benchCrc(16'h0000, 8'h0F);
      sendByte(8'h0F);
      sendByte(t1); mcrc = benchCrc(mcrc, t1);
      sendByte(t2); mcrc = benchCrc(mcrc, t2);
      for (int i = 0; i < n; i++) begin
        sendByte(VEC[v][i*8 +: 8]);
        mcrc = benchCrc(mcrc, VEC[v][i*8 +: 8]);
        mpad[i] = VEC[v][i*8 +: 8];
      end
      chk("R3 taLo cleared", {56'd0, taLo}, {56'd0, t1 & 8'hF8});
      chk("R3 taHi", {56'd0, taHi}, {56'd0, t2});
      chk("R4 pad contents", padData, modelPad());
      if (n == 8) begin
        readByte("R6 crc lo", got);
        chk("R5 R6 crc low inverted", {56'd0, got}, {56'd0, ~mcrc[7:0]});
        readByte("R6 crc hi", got);
        chk("R5 R6 crc high inverted", {56'd0, got}, {56'd0, ~mcrc[15:8]});
        readByte("R6 after crc", got);
        chk("R6 all ones", {56'd0, got}, 64'hFF);
        sendByte(8'hEE);
        chk("R7 byte after full ignored", padData, modelPad());
      end
      doAbort(VEC[v][64], 1'b0, 8'h00);
      // ending offset in bits 2..0, partial flag in bit 5 (R4 R8 R9)
      chk("R4 R8 R9 status", {56'd0, esByte},
          {56'd0, 2'b00, (VEC[v][64] && n < 8), 2'b00, 3'(n - 1)});
      chk("R8 pad kept after abort", padData, modelPad());
    end

    // R9: new transaction clears partial flag
    doAbort(1'b1, 1'b0, 8'h00);
    sendByte(8'h0F);
    sendByte(8'h11);
    sendByte(8'h22);
    sendByte(8'h44); mpad[0] = 8'h44;
    doAbort(1'b1, 1'b0, 8'h00);
    chk("R8 partial after one byte", {56'd0, esByte}, 64'h20);
    sendByte(8'h0F);
    chk("R9 new txn clears status", {56'd0, esByte}, 64'h00);
    // R7: read before full
    sendByte(8'h90);
    sendByte(8'h91);
    readByte("R7 early read", got);
    chk("R7 early read all ones", {56'd0, got}, 64'hFF);
    // R11: byte with abort is kept
    sendByte(8'h61); mpad[0] = 8'h61;
    doAbort(1'b0, 1'b1, 8'h62); mpad[1] = 8'h62;
    chk("R11 byte with abort stored", padData, modelPad());
    chk("R11 offset moves, no partial", {56'd0, esByte}, 64'h01);
    // R2: after abort, block is idle; non-command byte is skipped
    sendByte(8'h55);
    sendByte(8'hF7);
    sendByte(8'h33);
    chk("R2 skip keeps taLo", {56'd0, taLo}, 64'h90);
    chk("R2 skip keeps taHi", {56'd0, taHi}, 64'h91);
    doAbort(1'b0, 1'b0, 8'h00);
    // R2: command together with abort does not start
    doAbort(1'b0, 1'b1, 8'h0F);
    sendByte(8'hC8);
    sendByte(8'hD9);
    chk("R2 cmd with abort ignored", {56'd0, taLo}, 64'h90);
    chk("R2 cmd with abort ignored taHi", {56'd0, taHi}, 64'h91);
    doAbort(1'b0, 1'b0, 8'h00);
    readByte("R7 idle read", got);
    chk("R7 idle read all ones", {56'd0, got}, 64'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule